// File: doc/BRIEF.md
# Row and Frame Timing Sequencer

This block drives the per-row control pulses of a row-sequential image sensor. It runs from one master clock and three external triggers: frame, row and shutter. Each accepted row trigger starts a fixed sequence with three parts. The first is an analog window, in which the column gain stage is enabled and two levels are held in turn: the signal level first, then the reset level. Two converter passes follow, one for each of the two columns that share a converter. On the last cycle of the second pass, a transfer strobe moves the row from the conversion buffer to the readout buffer.

Readout of the previous row runs while the converters work. The readout enable is forced low for the whole analog window, so that switching noise stays out of sampling. The block has no rate registers. The frame rate comes only from how far apart the external triggers are.

The frame trigger restarts the readout row address at zero. The shutter trigger restarts a second pointer that marks which row receives a pixel reset. That pointer advances with each accepted row, which gives a rolling electronic shutter.

Top module: `rowFrameTimer`

## Requirements
- R1: After reset, every strobe and enable output is low, `busy` is low, and both `sampleRow` and `rstRow` are zero.
- R2: A row trigger is accepted only when all of these hold: the sequencer is idle, rows remain in the frame, and neither frame nor shutter trigger is high in the same cycle. From the next cycle, `gainEn` is high for SH_CLKS cycles. `sampSig` is high for the first SH_CLKS/2 of those cycles and `sampRst` for the rest.
- R3: Right after the analog window, `convEn` is high for 2*CONV_CLKS cycles. `convSel` is 0 for the first CONV_CLKS of them and 1 for the second CONV_CLKS.
- R4: `xferStb` is high for exactly one cycle, the last cycle of the second pass. In the cycle after it the sequencer is idle: `gainEn`, `convEn` and `busy` are low.
- R5: `readEn` is high only when both of these hold: a transfer strobe has occurred since the last frame trigger, and `gainEn` is low.
- R6: A row trigger that arrives while the sequence is running has no effect. The running sequence and `sampleRow` continue unchanged.
- R7: A frame trigger ends any running sequence in the next cycle and clears the readout-valid state. The next accepted row then has `sampleRow` = 0, and each later accepted row increments it by one.
- R8: Once NUM_ROWS rows have been accepted in a frame, further row triggers are ignored until a frame trigger.
- R9: Before any shutter trigger, `pixRstEn` stays low. A shutter trigger sets the reset pointer to zero. From then on, each accepted row raises `pixRstEn` throughout its analog window, and `rstRow` shows the pointer value, which then increments by one.
- R10: A row trigger that coincides with a frame or shutter trigger is not accepted. The other trigger still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTrig | input | 1 | Frame start trigger |
| rowTrig | input | 1 | Row start trigger |
| shutterTrig | input | 1 | Rolling shutter start trigger |
| gainEn | output | 1 | Column gain stage enable (analog window) |
| sampSig | output | 1 | Signal-level hold strobe |
| sampRst | output | 1 | Reset-level hold strobe |
| convEn | output | 1 | Converter pass active |
| convSel | output | 1 | Column select of the shared converter (0 first pass, 1 second) |
| xferStb | output | 1 | Conversion-to-readout buffer transfer |
| readEn | output | 1 | Digital readout permitted |
| pixRstEn | output | 1 | Pixel reset enable for row `rstRow` |
| sampleRow | output | ROW_W | Address of the row being sampled |
| rstRow | output | ROW_W | Address of the row being reset |
| busy | output | 1 | Row sequence running |

## Verification
The assertions assume that the triggers are synchronous to the master clock. They also assume that a trigger that must start something is held for one cycle only, because a long row trigger would restart the sequence as soon as it returns to idle. The bench drives every trigger as a single-cycle pulse, changed on the falling edge. It spaces row triggers so that each sequence completes, except in the scenarios that fire a row trigger mid-sequence or together with a frame or shutter trigger on purpose. Small parameter values keep the row and frame counts short enough to reach the end-of-frame limit.

// File: rtl/row_timer_pkg.sv
package row_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SH    = 2'd1,
    PH_CONV1 = 2'd2,
    PH_CONV2 = 2'd3
  } phase_e;

  // strobes passed from the sequencer to the address path
  typedef struct packed {
    logic rowStart;
    logic inSh;
    logic xferStb;
  } seqStrobe_t;

endpackage

// File: rtl/rowSeqCtrl.sv
module rowSeqCtrl
  import row_timer_pkg::*;
#(
  parameter int SH_CLKS   = 90,
  parameter int CONV_CLKS = 130
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTrig,
  input  logic       rowTrig,
  input  logic       shutterTrig,
  input  logic       rowAvail,
  output seqStrobe_t stb,
  output logic       gainEn,
  output logic       sampSig,
  output logic       sampRst,
  output logic       convEn,
  output logic       convSel,
  output logic       busy
);
  localparam int MAX_PH = (SH_CLKS > CONV_CLKS) ? SH_CLKS : CONV_CLKS;
  localparam int CW     = $clog2(MAX_PH + 1);
  localparam logic [CW-1:0] SH_LAST   = CW'(SH_CLKS - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CLKS - 1);
  localparam logic [CW-1:0] SH_HALF   = CW'(SH_CLKS / 2);

  phase_e        phase;
  logic [CW-1:0] phCnt;
  logic          startRow;

  assign startRow = (phase == PH_IDLE) && rowTrig && rowAvail && !frameTrig && !shutterTrig;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      phCnt <= '0;
    end else if (frameTrig) begin
      phase <= PH_IDLE;
      phCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startRow) begin
            phase <= PH_SH;
            phCnt <= '0;
          end
        end
        PH_SH: begin
          if (phCnt == SH_LAST) begin
            phase <= PH_CONV1;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        PH_CONV1: begin
          if (phCnt == CONV_LAST) begin
            phase <= PH_CONV2;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        PH_CONV2: begin
          if (phCnt == CONV_LAST) begin
            phase <= PH_IDLE;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          phCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    gainEn  = (phase == PH_SH);
    sampSig = gainEn && (phCnt < SH_HALF);
    sampRst = gainEn && (phCnt >= SH_HALF);
    convEn  = (phase == PH_CONV1) || (phase == PH_CONV2);
    convSel = (phase == PH_CONV2);
    busy    = (phase != PH_IDLE);
    stb.rowStart = startRow;
    stb.inSh     = gainEn;
    stb.xferStb  = (phase == PH_CONV2) && (phCnt == CONV_LAST) && !frameTrig;
  end

endmodule

// File: rtl/rowAddrPath.sv
module rowAddrPath
  import row_timer_pkg::*;
#(
  parameter int NUM_ROWS = 2196,
  parameter int ROW_W    = $clog2(NUM_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameTrig,
  input  logic             shutterTrig,
  input  seqStrobe_t       stb,
  output logic             rowAvail,
  output logic             rstThisRow,
  output logic             readEn,
  output logic [ROW_W-1:0] sampleRow,
  output logic [ROW_W-1:0] rstRow
);
  localparam logic [ROW_W-1:0] ROW_END  = ROW_W'(NUM_ROWS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

  logic [ROW_W-1:0] nextRow;
  logic [ROW_W-1:0] rstPtr;
  logic             rstArmed;
  logic             dataValid;

  assign rowAvail = (nextRow < ROW_END);
  assign readEn   = dataValid && !stb.inSh;

  // readout row address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextRow   <= '0;
      sampleRow <= '0;
      dataValid <= 1'b0;
    end else if (frameTrig) begin
      nextRow   <= '0;
      dataValid <= 1'b0;
    end else begin
      if (stb.rowStart) begin
        sampleRow <= nextRow;
        nextRow   <= nextRow + 1'b1;
      end
      if (stb.xferStb) dataValid <= 1'b1;
    end
  end

  // rolling shutter reset pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstPtr     <= '0;
      rstArmed   <= 1'b0;
      rstThisRow <= 1'b0;
      rstRow     <= '0;
    end else if (shutterTrig) begin
      rstPtr     <= '0;
      rstArmed   <= 1'b1;
    end else if (stb.rowStart) begin
      rstThisRow <= rstArmed;
      if (rstArmed) begin
        rstRow <= rstPtr;
        if (rstPtr == ROW_LAST) begin
          rstArmed <= 1'b0;
        end
        rstPtr <= rstPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rowFrameTimer.sv
module rowFrameTimer
  import row_timer_pkg::*;
#(
  parameter int SH_CLKS   = 90,
  parameter int CONV_CLKS = 130,
  parameter int NUM_ROWS  = 2196,
  localparam int ROW_W    = $clog2(NUM_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameTrig,
  input  logic             rowTrig,
  input  logic             shutterTrig,
  output logic             gainEn,
  output logic             sampSig,
  output logic             sampRst,
  output logic             convEn,
  output logic             convSel,
  output logic             xferStb,
  output logic             readEn,
  output logic             pixRstEn,
  output logic [ROW_W-1:0] sampleRow,
  output logic [ROW_W-1:0] rstRow,
  output logic             busy
);
  seqStrobe_t stb;
  logic       rowAvail;
  logic       rstThisRow;

  rowSeqCtrl #(.SH_CLKS(SH_CLKS), .CONV_CLKS(CONV_CLKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameTrig(frameTrig), .rowTrig(rowTrig),
    .shutterTrig(shutterTrig), .rowAvail(rowAvail), .stb(stb),
    .gainEn(gainEn), .sampSig(sampSig), .sampRst(sampRst),
    .convEn(convEn), .convSel(convSel), .busy(busy)
  );

  rowAddrPath #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) i_path (
    .clk(clk), .rstN(rstN), .frameTrig(frameTrig), .shutterTrig(shutterTrig),
    .stb(stb), .rowAvail(rowAvail), .rstThisRow(rstThisRow), .readEn(readEn),
    .sampleRow(sampleRow), .rstRow(rstRow)
  );

  assign xferStb  = stb.xferStb;
  assign pixRstEn = gainEn && rstThisRow;

endmodule

// File: rtl/rowFrameTimerChk.sv
module rowFrameTimerChk (
  input logic clk,
  input logic rstN,
  input logic frameTrig,
  input logic rowTrig,
  input logic gainEn,
  input logic sampSig,
  input logic sampRst,
  input logic convEn,
  input logic convSel,
  input logic xferStb,
  input logic readEn,
  input logic pixRstEn
);
  assert_gain_from_trig_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gainEn) |-> $past(rowTrig));
  assert_one_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampSig, sampRst}) && ((sampSig || sampRst) == gainEn));
  assert_conv_after_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (gainEn && !frameTrig) |=> (gainEn || (convEn && !convSel)));
  assert_xfer_in_pass2_R4: assert property (@(posedge clk) disable iff (!rstN)
    xferStb |-> (convEn && convSel));
  assert_idle_after_xfer_R4: assert property (@(posedge clk) disable iff (!rstN)
    xferStb |=> (!convEn && !gainEn && !xferStb));
  assert_read_blanked_R5: assert property (@(posedge clk) disable iff (!rstN)
    gainEn |-> !readEn);
  assert_busy_trig_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (convEn && rowTrig) |=> !gainEn);
  assert_frame_clears_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameTrig |=> (!readEn && !convEn && !gainEn));
  assert_pixrst_in_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    pixRstEn |-> gainEn);
endmodule

bind rowFrameTimer rowFrameTimerChk i_chk (
  .clk(clk), .rstN(rstN), .frameTrig(frameTrig), .rowTrig(rowTrig),
  .gainEn(gainEn), .sampSig(sampSig), .sampRst(sampRst), .convEn(convEn),
  .convSel(convSel), .xferStb(xferStb), .readEn(readEn), .pixRstEn(pixRstEn)
);

// File: tb/test_rowFrameTimer.sv
`timescale 1ns/1ps
module test_rowFrameTimer;
  localparam int SH   = 8;
  localparam int CV   = 6;
  localparam int ROWS = 4;
  localparam int RW   = $clog2(ROWS + 1);
  localparam int SEQ  = SH + 2 * CV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTrig = 1'b0, rowTrig = 1'b0, shutterTrig = 1'b0;
  logic gainEn, sampSig, sampRst, convEn, convSel, xferStb, readEn, pixRstEn, busy;
  logic [RW-1:0] sampleRow, rstRow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rowFrameTimer #(.SH_CLKS(SH), .CONV_CLKS(CV), .NUM_ROWS(ROWS)) i_rowFrameTimer (
    .clk(clk), .rstN(rstN), .frameTrig(frameTrig), .rowTrig(rowTrig),
    .shutterTrig(shutterTrig), .gainEn(gainEn), .sampSig(sampSig), .sampRst(sampRst),
    .convEn(convEn), .convSel(convSel), .xferStb(xferStb), .readEn(readEn),
    .pixRstEn(pixRstEn), .sampleRow(sampleRow), .rstRow(rstRow), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one full row; optional row trigger injected mid-sequence (R6)
  task automatic runRow(input int expRow, input bit expRst, input int expRstRow,
                        input bit readPrev, input bit midTrig);
    @(negedge clk);
    chk("R5 readEn idle before row", readEn, readPrev);
    rowTrig = 1'b1;
    @(negedge clk);
    rowTrig = 1'b0;
    for (int i = 0; i < SEQ; i++) begin
      chk("R2 gainEn", gainEn, i < SH);
      chk("R2 sampSig", sampSig, i < SH / 2);
      chk("R2 sampRst", sampRst, (i >= SH / 2) && (i < SH));
      chk("R3 convEn", convEn, i >= SH);
      chk("R3 convSel", convSel, i >= SH + CV);
      chk("R4 xferStb", xferStb, i == SEQ - 1);
      chk("R5 readEn", readEn, readPrev && (i >= SH));
      chk("R7 R6 sampleRow", sampleRow, expRow);
      chk("R9 pixRstEn", pixRstEn, expRst && (i < SH));
      if (expRst) chk("R9 rstRow", rstRow, expRstRow);
      rowTrig = midTrig && (i == 10);
      @(negedge clk);
    end
    rowTrig = 1'b0;
    chk("R4 idle gainEn", gainEn, 0);
    chk("R4 idle convEn", convEn, 0);
    chk("R4 idle busy", busy, 0);
    chk("R5 readEn after xfer", readEn, 1);
  endtask

  task automatic pulse(input bit f, input bit r, input bit s);
    @(negedge clk);
    frameTrig = f; rowTrig = r; shutterTrig = s;
    @(negedge clk);
    frameTrig = 1'b0; rowTrig = 1'b0; shutterTrig = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 gainEn", gainEn, 0);
    chk("R1 convEn", convEn, 0);
    chk("R1 xferStb", xferStb, 0);
    chk("R1 readEn", readEn, 0);
    chk("R1 pixRstEn", pixRstEn, 0);
    chk("R1 busy", busy, 0);
    chk("R1 sampleRow", sampleRow, 0);
    chk("R1 rstRow", rstRow, 0);
    rstN = 1'b1;
  endtask

  task automatic testFirstFrame();
    pulse(1, 0, 0);
    runRow(0, 0, 0, 0, 0);
    runRow(1, 0, 0, 1, 1);
    pulse(0, 0, 1);
    runRow(2, 1, 0, 1, 0);
    runRow(3, 1, 1, 1, 0);
  endtask

  task automatic testExhausted();
    pulse(0, 1, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R8 no row past end", gainEn, 0);
      chk("R8 sampleRow held", sampleRow, 3);
      @(negedge clk);
    end
  endtask

  task automatic testCoincide();
    pulse(1, 1, 0);
    chk("R10 frame+row no start", gainEn, 0);
    chk("R10 frame+row busy", busy, 0);
    chk("R7 frame clears read", readEn, 0);
    runRow(0, 1, 2, 0, 0);
    pulse(0, 1, 1);
    chk("R10 shutter+row no start", gainEn, 0);
    runRow(1, 1, 0, 1, 0);
  endtask

  task automatic testAbort();
    pulse(0, 1, 0);
    repeat (10) @(negedge clk);
    chk("R7 running before abort", convEn, 1);
    pulse(1, 0, 0);
    chk("R7 abort convEn", convEn, 0);
    chk("R7 abort gainEn", gainEn, 0);
    chk("R7 abort readEn", readEn, 0);
    chk("R7 abort busy", busy, 0);
    runRow(0, 1, 2, 0, 0);
  endtask

  initial begin
    testReset();
    testFirstFrame();
    testExhausted();
    testCoincide();
    testAbort();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule